// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block sits in a device that configures itself from an external serial memory. After reset it watches a three-bit mode input. When all three bits are zero, it starts a load. It first holds the memory's address counter in reset. It then runs a configuration clock, derived from the system clock, and takes one bit from the memory on each rising edge of that clock.

The bit stream carries a sync pattern, a length field and then the payload. The loader looks for the sync pattern and reads the length field. It then shifts out exactly that many payload bits to the logic that consumes them. When the last payload bit has been taken, it raises `doneOut`. That signal doubles as the memory's chip deselect, so memory data is cut off first. One configuration clock later the loader raises `userEn`, which lets user outputs drive.

A pulse on `restartReq` once the load is complete acts like pulling the done line low. The loader returns to its mode check and starts again with a fresh memory reset.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rstN` is low and right after it rises, `cfgClk`, `memReset`, `doneOut`, `userEn` and `bitValid` are all 0.
- R2: A load starts from idle only when `modeSel` equals 3'b000. With any other code the block stays idle: no `memReset`, no `cfgClk` edge and no `doneOut`.
- R3: Every load, including one after a restart, begins with `memReset` high for exactly (2*INIT_CYC-1)*HALF system clocks. No `cfgClk` rising edge occurs while it is high.
- R4: `cfgClk` has a period of 2*HALF system clocks and stays high for HALF system clocks. It toggles only from the end of `memReset` until the cycle in which `userEn` rises.
- R5: One `memData` bit is sampled at each rising edge of `cfgClk`, on the same system clock edge at which `cfgClk` goes high.
- R6: The loader keeps sampling until the most recent PRE_W samples equal PRE_PAT, with the earliest sample as the MSB. The default pattern is 8'hF2.
- R7: The next LEN_W samples (24 by default) form the payload length, sent MSB first.
- R8: Exactly that many payload bits appear on `bitData`, in stream order. Each one comes with a one-cycle `bitValid` pulse in the system cycle after its sampling edge.
- R9: `doneOut` rises in the same cycle as the last payload `bitValid`. For a length of zero it rises right after the final length bit, and no `bitValid` occurs.
- R10: `userEn` rises exactly 2*HALF system clocks after `doneOut`, with exactly one more `cfgClk` rising edge in between. After that, `cfgClk` shows no rising edge.
- R11: A `restartReq` pulse while `userEn` is high drops `doneOut` and `userEn` in the next cycle. The block then returns to the mode check of R2.
- R12: `restartReq` before `userEn` has risen has no effect on the load in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Mode select; 3'b000 selects master serial loading |
| memData | input | 1 | Serial data from the configuration memory |
| restartReq | input | 1 | Request for a new load once the current one is complete |
| cfgClk | output | 1 | Configuration clock to the memory |
| memReset | output | 1 | Memory address counter reset, active high |
| doneOut | output | 1 | Load complete; also deselects the memory |
| userEn | output | 1 | Enable for user outputs |
| bitValid | output | 1 | One-cycle strobe for each payload bit |
| bitData | output | 1 | Payload bit, valid with `bitValid` |

## Verification
The assertions assume that `modeSel`, `restartReq` and `memData` are synchronous to `clk`. They also assume that `memData` holds still between rising edges of `cfgClk`, as a memory clocked by that same signal does. The bench keeps to these assumptions. It changes every input two nanoseconds after a system clock edge. Its memory model advances its address only on a `cfgClk` rising edge, clears the address on `memReset`, and returns a pulled-up 1 while it is deselected. The sync pattern is always preceded by ones or by the cleared sync register, so it can never match early.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_HUNT,
    ST_LEN,
    ST_DATA,
    ST_LAST,
    ST_USER
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic divRun;
    logic clkRun;
    logic memRst;
    logic clrCnt;
    logic incCnt;
    logic shiftHunt;
    logic shiftLen;
    logic emitBit;
  } dpStrobe_t;

  // conditions reported by datapath
  typedef struct packed {
    logic tick;
    logic initLast;
    logic huntHit;
    logic lenLast;
    logic lenZero;
    logic dataLast;
  } dpStatus_t;

endpackage

// File: rtl/serial_cfg_dp.sv
module serial_cfg_dp
  import serial_cfg_pkg::*;
#(
  parameter int HALF = 2,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PRE_PAT = 8'hF2,
  parameter int LEN_W = 24,
  parameter int INIT_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strb,
  input  logic      memData,
  output dpStatus_t stat,
  output logic      cfgClk,
  output logic      bitValid,
  output logic      bitData
);

  localparam int DIV_N = 2 * HALF;
  localparam int DIV_W = (DIV_N > 2) ? $clog2(DIV_N) : 1;
  localparam logic [DIV_W-1:0] RISE_AT = DIV_W'(HALF - 1);
  localparam logic [DIV_W-1:0] FALL_AT = DIV_W'(DIV_N - 1);
  localparam int CNT_W = LEN_W;

  logic [DIV_W-1:0] divCnt;
  logic             riseNow;
  logic             fallNow;
  logic             cfgClkQ;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] huntSr;
  logic [PRE_W-1:0] huntNext;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] lenNext;
  logic             bitValidQ;
  logic             bitDataQ;

  // clock divider
  assign riseNow = strb.divRun && (divCnt == RISE_AT);
  assign fallNow = strb.divRun && (divCnt == FALL_AT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!strb.divRun || divCnt == FALL_AT) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgClkQ <= 1'b0;
    end else if (!strb.divRun) begin
      cfgClkQ <= 1'b0;
    end else if (riseNow && strb.clkRun) begin
      cfgClkQ <= 1'b1;
    end else if (fallNow) begin
      cfgClkQ <= 1'b0;
    end
  end

  // shared counter: init periods, length bits, payload bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clrCnt) begin
      cnt <= '0;
    end else if (strb.incCnt) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // sync pattern window
  generate
    if (PRE_W == 1) begin : g_huntOne
      assign huntNext = memData;
    end else begin : g_huntMany
      assign huntNext = {huntSr[PRE_W-2:0], memData};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      huntSr <= '0;
    end else if (strb.memRst) begin
      huntSr <= '0;
    end else if (strb.shiftHunt) begin
      huntSr <= huntNext;
    end
  end

  // length field, MSB first
  assign lenNext = {lenQ[LEN_W-2:0], memData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
    end else if (strb.shiftLen) begin
      lenQ <= lenNext;
    end
  end

  // payload output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitValidQ <= 1'b0;
      bitDataQ  <= 1'b0;
    end else begin
      bitValidQ <= strb.emitBit;
      if (strb.emitBit) bitDataQ <= memData;
    end
  end

  assign stat.tick     = riseNow;
  assign stat.initLast = (cnt == CNT_W'(INIT_CYC - 1));
  assign stat.huntHit  = (huntNext == PRE_PAT);
  assign stat.lenLast  = (cnt == CNT_W'(LEN_W - 1));
  assign stat.lenZero  = (lenNext == '0);
  assign stat.dataLast = (cnt == lenQ - CNT_W'(1));

  assign cfgClk   = cfgClkQ;
  assign bitValid = bitValidQ;
  assign bitData  = bitDataQ;

  p_init_clk_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.memRst |-> !cfgClkQ)
    else $error("cfgClk high during memory reset");

  p_clk_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClkQ) |-> $past(strb.clkRun))
    else $error("cfgClk rose outside a run window");

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitValidQ |=> !bitValidQ)
    else $error("bitValid longer than one cycle");

endmodule

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
  import serial_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       restartReq,
  input  dpStatus_t  stat,
  output dpStrobe_t  strb,
  output logic       doneOut,
  output logic       userEn,
  output logic       memReset
);

  loadState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb = '0;
    strb.divRun = (state != ST_IDLE);
    strb.clkRun = (state == ST_HUNT) || (state == ST_LEN) ||
                  (state == ST_DATA) || (state == ST_LAST);
    strb.memRst = (state == ST_INIT);
    unique case (state)
      ST_IDLE: begin
        if (modeSel == 3'b000) begin
          stateNext   = ST_INIT;
          strb.clrCnt = 1'b1;
        end
      end
      ST_INIT: begin
        if (stat.tick) begin
          if (stat.initLast) begin
            stateNext   = ST_HUNT;
            strb.clrCnt = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
      end
      ST_HUNT: begin
        if (stat.tick) begin
          strb.shiftHunt = 1'b1;
          if (stat.huntHit) begin
            stateNext   = ST_LEN;
            strb.clrCnt = 1'b1;
          end
        end
      end
      ST_LEN: begin
        if (stat.tick) begin
          strb.shiftLen = 1'b1;
          if (stat.lenLast) begin
            stateNext   = stat.lenZero ? ST_LAST : ST_DATA;
            strb.clrCnt = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (stat.tick) begin
          strb.emitBit = 1'b1;
          if (stat.dataLast) stateNext = ST_LAST;
          else               strb.incCnt = 1'b1;
        end
      end
      ST_LAST: begin
        if (stat.tick) stateNext = ST_USER;
      end
      ST_USER: begin
        if (restartReq) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign doneOut  = (state == ST_LAST) || (state == ST_USER);
  assign userEn   = (state == ST_USER);
  assign memReset = (state == ST_INIT);

  p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && modeSel != 3'b000) |=> (state == ST_IDLE))
    else $error("load started with a non-serial mode");

  p_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_USER && restartReq) |=> !doneOut)
    else $error("restart did not drop done");

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int HALF = 2,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PRE_PAT = 8'hF2,
  parameter int LEN_W = 24,
  parameter int INIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       memData,
  input  logic       restartReq,
  output logic       cfgClk,
  output logic       memReset,
  output logic       doneOut,
  output logic       userEn,
  output logic       bitValid,
  output logic       bitData
);

  dpStrobe_t strb;
  dpStatus_t stat;

  serial_cfg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .restartReq (restartReq),
    .stat       (stat),
    .strb       (strb),
    .doneOut    (doneOut),
    .userEn     (userEn),
    .memReset   (memReset)
  );

  serial_cfg_dp #(
    .HALF     (HALF),
    .PRE_W    (PRE_W),
    .PRE_PAT  (PRE_PAT),
    .LEN_W    (LEN_W),
    .INIT_CYC (INIT_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memData  (memData),
    .stat     (stat),
    .cfgClk   (cfgClk),
    .bitValid (bitValid),
    .bitData  (bitData)
  );

  p_done_order_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userEn) |-> $past(doneOut))
    else $error("userEn rose without done");

  p_user_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (userEn && $past(userEn)) |-> !$rose(cfgClk))
    else $error("cfgClk edge after userEn");

endmodule

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = 2;
  localparam int PRE_W = 8;
  localparam logic [7:0] PRE_PAT = 8'hF2;
  localparam int LEN_W = 24;
  localparam int INIT_CYC = 4;
  localparam int NVEC = 5;
  // {lead ones, length, seed, restart poke mid-load}
  localparam logic [32:0] VEC [NVEC] = '{
    {8'd0, 8'd5,  16'h0013, 1'b0},
    {8'd3, 8'd16, 16'hA5C3, 1'b0},
    {8'd7, 8'd1,  16'h0001, 1'b0},
    {8'd2, 8'd0,  16'h0000, 1'b0},
    {8'd1, 8'd40, 16'h6E29, 1'b1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [2:0] modeSel;
  logic       memData;
  logic       restartReq;
  logic       cfgClk, memReset, doneOut, userEn, bitValid, bitData;

  int errs = 0;
  int checks = 0;
  bit stream [0:511];
  int addr = 0;
  int riseCnt = 0;
  int capCnt = 0;
  bit capBits [0:1023];
  longint lastRise = 0;
  int badPer = 0;
  int badHigh = 0;

  serial_cfg_loader dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .memData(memData),
    .restartReq(restartReq), .cfgClk(cfgClk), .memReset(memReset),
    .doneOut(doneOut), .userEn(userEn), .bitValid(bitValid), .bitData(bitData)
  );

  // memory model: deselected or in reset reads as pulled-up 1
  assign memData = (memReset || doneOut) ? 1'b1 : ((addr < 512) ? stream[addr] : 1'b1);

  always @(posedge cfgClk or posedge memReset) begin
    if (memReset) begin
      addr <= 0;
      lastRise <= 0;
    end else begin
      if (!doneOut) addr <= addr + 1;
      if (lastRise != 0 && ($time - lastRise) != 2 * HALF * 8) badPer <= badPer + 1;
      lastRise <= $time;
    end
  end

  always @(negedge cfgClk) begin
    if (lastRise != 0 && ($time - lastRise) != HALF * 8) badHigh <= badHigh + 1;
  end

  always @(posedge cfgClk) riseCnt <= riseCnt + 1;

  always @(negedge clk) begin
    if (bitValid === 1'b1) begin
      capBits[capCnt] <= bitData;
      capCnt <= capCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic runLoad(input int lead, input int len, input logic [15:0] seed,
                         input bit poke, input bit viaRestart);
    int idx, n, hi, g, r0, c0, r1, mism, bp0, bh0;
    bit pokeDone;
    logic [23:0] lenVec;
    lenVec = 24'(len);
    for (int i = 0; i < 512; i++) stream[i] = 1'b1;
    idx = lead;
    for (int b = PRE_W - 1; b >= 0; b--) begin stream[idx] = PRE_PAT[b]; idx++; end
    for (int b = LEN_W - 1; b >= 0; b--) begin stream[idx] = lenVec[b]; idx++; end
    for (int i = 0; i < len; i++) begin stream[idx] = seed[i % 16]; idx++; end
    r0 = riseCnt; c0 = capCnt; bp0 = badPer; bh0 = badHigh;

    if (viaRestart) begin
      restartReq = 1'b1;
      step();
      restartReq = 1'b0;
      chk(!doneOut && !userEn, "R11", "done/userEn after restart", {doneOut, userEn}, 0);
    end else begin
      modeSel = 3'b000;
      step();
    end

    n = 0;
    while (!memReset && n < 20) begin step(); n++; end
    hi = 0;
    while (memReset && hi < 200) begin step(); hi++; end
    chk(hi == (2 * INIT_CYC - 1) * HALF, "R3", "memReset width", hi, (2 * INIT_CYC - 1) * HALF);
    chk(riseCnt == r0, "R3", "cfgClk rises during memReset", riseCnt - r0, 0);

    n = 0; pokeDone = 1'b0;
    while (!doneOut && n < 5000) begin
      if (poke && !pokeDone && (capCnt - c0) >= len / 2) begin
        restartReq = 1'b1;   // R12: must be ignored mid-load
        step();
        restartReq = 1'b0;
        pokeDone = 1'b1;
      end else begin
        step();
      end
      n++;
    end
    chk(doneOut, "R9", "done reached", doneOut, 1);
    if (len > 0)
      chk(bitValid && (capCnt - c0) == len - 1, "R9", "done with last bitValid",
          capCnt - c0 + bitValid, len);
    else
      chk(!bitValid && capCnt == c0, "R9", "no bits for zero length", capCnt - c0, 0);

    g = 0;
    while (!userEn && g < 100) begin step(); g++; end
    chk(g == 2 * HALF, "R10", "done to userEn cycles", g, 2 * HALF);
    chk(riseCnt - r0 == lead + PRE_W + LEN_W + len + 1, "R5", "cfgClk rising edges",
        riseCnt - r0, lead + PRE_W + LEN_W + len + 1);
    chk(badPer == bp0 && badHigh == bh0, "R4", "cfgClk period/high errors",
        (badPer - bp0) + (badHigh - bh0), 0);

    mism = 0;
    for (int i = 0; i < len; i++) if (capBits[c0 + i] != seed[i % 16]) mism++;
    chk(capCnt - c0 == len, "R7", "payload bit count", capCnt - c0, len);
    chk(mism == 0, poke ? "R12" : "R8", "payload mismatches", mism, 0);
    chk(!poke || userEn, "R12", "load completed despite restart", userEn, 1);

    r1 = riseCnt;
    repeat (24) step();
    chk(riseCnt == r1 && userEn && doneOut, "R10", "quiet after userEn", riseCnt - r1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit sawRst, sawDone;
    logic [15:0] seedV;
    rstN = 1'b0;
    modeSel = 3'b101;
    restartReq = 1'b0;
    repeat (3) step();
    chk({cfgClk, memReset, doneOut, userEn, bitValid} == 5'b0, "R1", "outputs in reset",
        {cfgClk, memReset, doneOut, userEn, bitValid}, 0);
    rstN = 1'b1;
    step();
    chk({cfgClk, memReset, doneOut, userEn, bitValid} == 5'b0, "R1", "outputs after reset",
        {cfgClk, memReset, doneOut, userEn, bitValid}, 0);

    sawRst = 1'b0; sawDone = 1'b0;
    for (int m = 1; m < 8; m++) begin
      modeSel = 3'(m);
      repeat (6) begin
        step();
        sawRst |= memReset;
        sawDone |= doneOut;
      end
    end
    chk(!sawRst && !sawDone && riseCnt == 0, "R2", "idle with nonzero modes",
        riseCnt + sawRst + sawDone, 0);

    // R6/R7/R8 across the table
    for (int v = 0; v < NVEC; v++) begin
      seedV = VEC[v][16:1];
      runLoad(int'(VEC[v][32:25]), int'(VEC[v][24:17]), seedV, VEC[v][0], v > 0);
    end

    // R11 then R2: restart with a non-serial mode stays idle
    modeSel = 3'b011;
    restartReq = 1'b1;
    step();
    restartReq = 1'b0;
    chk(!doneOut && !userEn, "R11", "restart drops done", {doneOut, userEn}, 0);
    begin
      int r0;
      r0 = riseCnt;
      sawRst = 1'b0;
      repeat (40) begin step(); sawRst |= memReset; end
      chk(!sawRst && riseCnt == r0 && !doneOut, "R2", "no load after restart in other mode",
          (riseCnt - r0) + sawRst, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule